// File: doc/BRIEF.md
# Signed Double-Width Integer Divider

This block divides a signed dividend of twice the operand width by a signed divisor of one operand width. It returns a single-width quotient and remainder. The operand width is selected per operation as one quarter, one half or all of `XLEN` (8, 16 or 32 bits at the default). A caller raises `start` for one cycle with the operands. The block shows `busy` while it works and then pulses `done` for one cycle, with the results and the error flag valid in that cycle.

Internally the signs are removed first and the magnitudes are divided by a restoring shift-subtract loop that retires one quotient bit per clock. The signs are then put back. The quotient is truncated toward zero and the remainder carries the dividend's sign. A zero divisor, or a quotient that cannot be represented in the operand width, is reported on `div_err` instead of producing a result. In that case the result outputs keep their previous values.

Top module: `sdiv_core`

## Requirements
- R1: `size` selects the operand width N: code 0 gives XLEN/4, code 1 gives XLEN/2, codes 2 and 3 give XLEN. Only bits [2N-1:0] of `dividend` and bits [N-1:0] of `divisor` are used. Results occupy bits [N-1:0] of `quotient` and `remainder`, and the bits above them read zero.
- R2: On success the quotient is the exact signed quotient truncated toward zero, in two's complement.
- R3: On success a non-zero remainder has the dividend's sign and a magnitude below the divisor's magnitude. The remainder satisfies dividend = quotient * divisor + remainder.
- R4: A zero divisor raises `div_err` in the `done` cycle and leaves `quotient` and `remainder` unchanged.
- R5: A true quotient above 2^(N-1)-1 or below -2^(N-1) raises `div_err` and leaves the outputs unchanged. A quotient of exactly -2^(N-1) is accepted.
- R6: A `start` seen while idle is accepted, and `busy` is high from the next edge until `done` rises. `busy` and `done` are never high together.
- R7: `done` is a single-cycle pulse. `div_err` is only high together with `done`. `quotient` and `remainder` change only at the edge that raises `done`.
- R8: `done` rises N+1 rising edges after the edge that accepts `start`. It rises after 1 edge when the divisor is zero or the quotient magnitude is at least 2^N.
- R9: A `start` raised while `busy` is high is ignored: it neither alters the running operation nor produces an extra `done`.
- R10: While `rst` is high, `busy`, `done` and `div_err` are low and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| size | input | 2 | Operand width select |
| dividend | input | 2*XLEN | Signed dividend, low 2N bits used |
| divisor | input | XLEN | Signed divisor, low N bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Zero divisor or quotient out of range, valid with done |
| quotient | output | XLEN | Signed quotient, zero-extended above N bits |
| remainder | output | XLEN | Signed remainder, zero-extended above N bits |

## Verification
The bench builds the block with the default `XLEN` of 32, so all three operand widths and the alias code 3 run on one instance. The 32-bit case exercises the 64-bit dividend, the most negative dividend and the slowest 33-edge latency. The byte and halfword cases are driven with unused upper port bits filled with noise. Both overflow paths are covered: the early path, where the quotient magnitude reaches 2^N, and the late range check that rejects +2^(N-1) but accepts -2^(N-1).

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } sdiv_state_e;

  // operand width for a size code: quarter, half or full XLEN
  function automatic int unsigned op_bits(input logic [1:0] sz, input int unsigned xlen);
    case (sz)
      2'd0:    return xlen / 4;
      2'd1:    return xlen / 2;
      default: return xlen;
    endcase
  endfunction

endpackage

// File: rtl/sdiv_prep.sv
`timescale 1ns/1ps
module sdiv_prep #(
  parameter int XLEN = 32
) (
  input  logic [1:0]                 size,
  input  logic [2*XLEN-1:0]          dividend,
  input  logic [XLEN-1:0]            divisor,
  output logic [$clog2(XLEN+1)-1:0]  nbits,
  output logic                       dvd_neg,
  output logic                       dsr_neg,
  output logic                       dsr_zero,
  output logic                       early_ovf,
  output logic [XLEN-1:0]            dsr_mag,
  output logic [XLEN-1:0]            rem_init,
  output logic [XLEN-1:0]            low_init
);
  localparam int DW = 2 * XLEN;
  localparam int CW = $clog2(XLEN + 1);

  int unsigned     nb;
  logic [DW-1:0]   dmask, dsh, dext, dmag, hi;
  logic [XLEN-1:0] smask, ssh, sext;

  always_comb begin
    nb      = sdiv_pkg::op_bits(size, XLEN);
    nbits   = CW'(nb);
    // dividend: sign-extend from 2N bits, then take magnitude
    dmask   = {DW{1'b1}} >> (DW - 2 * nb);
    dsh     = dividend >> (2 * nb - 1);
    dvd_neg = dsh[0];
    dext    = dvd_neg ? (dividend | ~dmask) : (dividend & dmask);
    dmag    = dvd_neg ? (~dext + 1'b1) : dext;
    // divisor: sign-extend from N bits, then take magnitude
    smask   = {XLEN{1'b1}} >> (XLEN - nb);
    ssh     = divisor >> (nb - 1);
    dsr_neg = ssh[0];
    sext    = dsr_neg ? (divisor | ~smask) : (divisor & smask);
    dsr_mag = dsr_neg ? (~sext + 1'b1) : sext;
    dsr_zero = (dsr_mag == '0);
    // quotient magnitude reaches 2^N exactly when the upper half is not below the divisor
    hi        = dmag >> nb;
    early_ovf = dsr_zero || (hi >= {{XLEN{1'b0}}, dsr_mag});
    rem_init  = hi[XLEN-1:0];
    low_init  = dmag[XLEN-1:0] << (XLEN - nb);
  end

endmodule

// File: rtl/sdiv_step.sv
`timescale 1ns/1ps
module sdiv_step #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rem_in,
  input  logic [XLEN-1:0] low_in,
  input  logic [XLEN-1:0] dsr_mag,
  output logic [XLEN-1:0] rem_out,
  output logic [XLEN-1:0] low_out
);
  logic [XLEN:0] trial, diff;
  logic          qbit;

  always_comb begin
    trial   = {rem_in, low_in[XLEN-1]};
    diff    = trial - {1'b0, dsr_mag};
    qbit    = (trial >= {1'b0, dsr_mag});
    rem_out = qbit ? diff[XLEN-1:0] : trial[XLEN-1:0];
    low_out = {low_in[XLEN-2:0], qbit};
  end

endmodule

// File: rtl/sdiv_fixup.sv
`timescale 1ns/1ps
module sdiv_fixup #(
  parameter int XLEN = 32
) (
  input  logic [$clog2(XLEN+1)-1:0] nbits,
  input  logic                      q_neg,
  input  logic                      r_neg,
  input  logic [XLEN-1:0]           q_mag,
  input  logic [XLEN-1:0]           r_mag,
  output logic [XLEN-1:0]           quo,
  output logic [XLEN-1:0]           rem,
  output logic                      range_err
);
  logic [XLEN-1:0] lim, mask;

  always_comb begin
    lim       = {{(XLEN-1){1'b0}}, 1'b1} << (nbits - 1'b1);
    mask      = {XLEN{1'b1}} >> (XLEN - int'(nbits));
    range_err = q_neg ? (q_mag > lim) : (q_mag >= lim);
    quo       = (q_neg ? (~q_mag + 1'b1) : q_mag) & mask;
    rem       = (r_neg ? (~r_mag + 1'b1) : r_mag) & mask;
  end

endmodule

// File: rtl/sdiv_core.sv
`timescale 1ns/1ps
module sdiv_core #(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          size,
  input  logic [2*XLEN-1:0]   dividend,
  input  logic [XLEN-1:0]     divisor,
  output logic                busy,
  output logic                done,
  output logic                div_err,
  output logic [XLEN-1:0]     quotient,
  output logic [XLEN-1:0]     remainder
);
  import sdiv_pkg::*;
  localparam int CW = $clog2(XLEN + 1);

  sdiv_state_e     state;
  logic [CW-1:0]   cnt, nbits_r;
  logic [XLEN-1:0] rem_r, low_r, dsr_r;
  logic            qneg_r, rneg_r, err_pend;

  logic [CW-1:0]   p_nbits;
  logic            p_dneg, p_sneg, p_zero, p_early;
  logic [XLEN-1:0] p_dsr, p_rem, p_low;
  logic [XLEN-1:0] s_rem, s_low;
  logic [XLEN-1:0] f_quo, f_rem;
  logic            f_err;

  sdiv_prep #(.XLEN(XLEN)) u_prep (
    .size(size), .dividend(dividend), .divisor(divisor),
    .nbits(p_nbits), .dvd_neg(p_dneg), .dsr_neg(p_sneg), .dsr_zero(p_zero),
    .early_ovf(p_early), .dsr_mag(p_dsr), .rem_init(p_rem), .low_init(p_low)
  );

  sdiv_step #(.XLEN(XLEN)) u_step (
    .rem_in(rem_r), .low_in(low_r), .dsr_mag(dsr_r),
    .rem_out(s_rem), .low_out(s_low)
  );

  sdiv_fixup #(.XLEN(XLEN)) u_fix (
    .nbits(nbits_r), .q_neg(qneg_r), .r_neg(rneg_r),
    .q_mag(low_r), .r_mag(rem_r),
    .quo(f_quo), .rem(f_rem), .range_err(f_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      nbits_r   <= '0;
      rem_r     <= '0;
      low_r     <= '0;
      dsr_r     <= '0;
      qneg_r    <= 1'b0;
      rneg_r    <= 1'b0;
      err_pend  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      div_err   <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            busy     <= 1'b1;
            nbits_r  <= p_nbits;
            cnt      <= p_nbits;
            rem_r    <= p_rem;
            low_r    <= p_low;
            dsr_r    <= p_dsr;
            qneg_r   <= p_dneg ^ p_sneg;
            rneg_r   <= p_dneg;
            err_pend <= p_zero | p_early;
            state    <= (p_zero | p_early) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          rem_r <= s_rem;
          low_r <= s_low;
          cnt   <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
          if (err_pend || f_err) begin
            div_err <= 1'b1;
          end else begin
            quotient  <= f_quo;
            remainder <= f_rem;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdiv_checker.sv
`timescale 1ns/1ps
module sdiv_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            div_err,
  input logic [XLEN-1:0] quotient,
  input logic [XLEN-1:0] remainder
);

  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r6_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
    div_err |-> done);

  a_r7_hold_outside_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R4 and R5: a failed operation leaves the results untouched
  a_r4_err_holds_results: assert property (@(posedge clk) disable iff (rst)
    (done && div_err) |-> ($stable(quotient) && $stable(remainder)));

  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !div_err));

endmodule

bind sdiv_core sdiv_checker #(.XLEN(XLEN)) u_sdiv_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .div_err(div_err), .quotient(quotient), .remainder(remainder)
);

// File: tb/tb_sdiv_core.sv
`timescale 1ns/1ps
module tb_sdiv_core;
  localparam int XLEN = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [63:0] dvd = '0;
  logic [31:0] dsr = '0;
  logic        busy, done, div_err;
  logic [31:0] quotient, remainder;

  int vectors = 0;
  int fails = 0;
  logic [31:0] held_q = '0;
  logic [31:0] held_r = '0;

  always #10 clk = ~clk;

  sdiv_core #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .start(start), .size(size), .dividend(dvd),
    .divisor(dsr), .busy(busy), .done(done), .div_err(div_err),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] s, input logic [63:0] a, input logic [31:0] b,
                                output bit e, output logic [31:0] q, output logic [31:0] r,
                                output int lat);
    int n;
    logic [63:0] m2, m1, av, am, bv, bm, qm, rm, lim;
    bit sa, sb, ng;
    n  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m2 = (n == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * n)) - 64'd1);
    m1 = (64'd1 << n) - 64'd1;
    av = a & m2;
    sa = av[2 * n - 1];
    am = sa ? ((~av + 64'd1) & m2) : av;
    bv = {32'd0, b} & m1;
    sb = bv[n - 1];
    bm = sb ? ((~bv + 64'd1) & m1) : bv;
    q = '0; r = '0; e = 1'b0; lat = n + 1;
    if (bm == 64'd0) begin e = 1'b1; lat = 1; return; end
    qm = am / bm;
    rm = am % bm;
    if (qm >= (64'd1 << n)) begin e = 1'b1; lat = 1; return; end
    ng  = sa ^ sb;
    lim = 64'd1 << (n - 1);
    if (ng ? (qm > lim) : (qm >= lim)) begin e = 1'b1; return; end
    q = 32'((ng ? (~qm + 64'd1) : qm) & m1);
    r = 32'((sa ? (~rm + 64'd1) : rm) & m1);
  endfunction

  // drive one operation and check everything visible at the ports
  task automatic run_op(input logic [1:0] s, input logic [63:0] a, input logic [31:0] b);
    bit e;
    logic [31:0] eq, er, xq, xr;
    int lat;
    int cyc;
    model(s, a, b, e, eq, er, lat);
    @(negedge clk);
    size = s; dvd = a; dsr = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy === 1'b1, "R6", 64'(busy), 64'd1);
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, "R7", 64'(done), 64'd1);
    chk(cyc == lat + 1, "R8", 64'(cyc - 1), 64'(lat));
    chk(busy === 1'b0, "R6", 64'(busy), 64'd0);
    chk(div_err === e, (b == 32'd0 || e == 1'b0) ? "R4" : "R5", 64'(div_err), 64'(e));
    xq = e ? held_q : eq;
    xr = e ? held_r : er;
    chk(quotient === xq, e ? "R5" : "R2", 64'(quotient), 64'(xq));
    chk(remainder === xr, e ? "R5" : "R3", 64'(remainder), 64'(xr));
    held_q = quotient;
    held_r = remainder;
    @(negedge clk);
    chk(done === 1'b0 && div_err === 1'b0, "R7", 64'({done, div_err}), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10: idle outputs under reset
    chk(busy === 1'b0 && done === 1'b0 && div_err === 1'b0, "R10",
        64'({busy, done, div_err}), 64'd0);
    chk(quotient === 32'd0 && remainder === 32'd0, "R10",
        {quotient, remainder}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: noise above the active fields is ignored, results are zero-extended
    run_op(2'd0, 64'hDEAD_BEEF_CAFE_0007, 32'hFFFF_FF02);
    chk(quotient === 32'h0000_0003 && remainder === 32'h0000_0001, "R1",
        {quotient, remainder}, {32'h3, 32'h1});
    run_op(2'd1, 64'h1234_5678_FFFF_FFF9, 32'hABCD_0002);
    chk(quotient === 32'h0000_FFFD && remainder === 32'h0000_FFFF, "R1",
        {quotient, remainder}, {32'hFFFD, 32'hFFFF});

    // R2 and R3: all sign combinations
    run_op(2'd0, 64'hFFF9, 32'h02);
    run_op(2'd0, 64'h0007, 32'hFE);
    run_op(2'd0, 64'hFFF9, 32'hFE);
    chk(quotient === 32'h03 && remainder === 32'hFF, "R3", {quotient, remainder}, {32'h03, 32'hFF});
    run_op(2'd2, 64'hFFFF_FFFF_FFFF_FF9C, 32'd7);
    run_op(2'd3, 64'd1000003, 32'hFFFF_FFF9);

    // R4: zero divisor keeps the previous results
    run_op(2'd0, 64'h0011, 32'h00);
    run_op(2'd2, 64'h0123_4567_89AB_CDEF, 32'h0);

    // R5: range limits
    run_op(2'd0, 64'hFF80, 32'h01);
    chk(quotient === 32'h80 && div_err === 1'b0, "R5", 64'(quotient), 64'h80);
    run_op(2'd0, 64'hFF80, 32'hFF);
    run_op(2'd0, 64'h7FFF, 32'h01);
    run_op(2'd1, 64'hFFFF_8000, 32'hFFFF);
    run_op(2'd2, 64'hFFFF_FFFF_8000_0000, 32'hFFFF_FFFF);
    run_op(2'd2, 64'h8000_0000_0000_0000, 32'h1);
    run_op(2'd2, 64'h3FFF_FFFF_FFFF_FFFF, 32'h7FFF_FFFF);
    run_op(2'd2, 64'hC000_0000_0000_0000, 32'h8000_0000);

    // R9: a start during busy is ignored
    begin
      bit e;
      logic [31:0] eq, er;
      int lat;
      int extra;
      model(2'd2, 64'd1000000, 32'd7, e, eq, er, lat);
      @(negedge clk);
      size = 2'd2; dvd = 64'd1000000; dsr = 32'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      size = 2'd0; dvd = 64'h5; dsr = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      chk(done === 1'b1 && div_err === 1'b0, "R9", 64'({done, div_err}), 64'h2);
      chk(quotient === eq && remainder === er, "R9", {quotient, remainder}, {eq, er});
      held_q = quotient;
      held_r = remainder;
      extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0 && busy === 1'b0, "R9", 64'(extra), 64'd0);
    end

    // randomized mix of widths, signs and magnitudes
    for (int k = 0; k < 600; k++) begin
      logic [1:0] s;
      int n;
      logic [63:0] a, lo;
      logic [31:0] b;
      s = 2'($urandom % 4);
      n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      b = $urandom;
      if ($urandom % 4 == 0) b = ($urandom % 2) ? ($urandom % 5) : (32'hFFFF_FFFF - ($urandom % 4));
      if ($urandom % 3 == 0) begin
        a = {$urandom, $urandom};
      end else begin
        lo = 64'($urandom) & ((64'd1 << n) - 64'd1);
        a  = lo[n - 1] ? ((64'hFFFF_FFFF_FFFF_FFFF << n) | lo) : lo;
      end
      run_op(s, a, b);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule